// File: doc/BRIEF.md
# Touch coordinate acquisition sequencer

This block sits between the pen interrupt of a four-wire resistive touch controller and a serial master that performs the individual conversions. The active-low pen input is synchronized to the system clock. It must then stay low for a settle window of `DEBOUNCE_CYC` system clocks. After that the sequencer runs one capture. It asks for a batch of X conversions and then a batch of Y conversions. For each conversion it issues a one-cycle request that carries the control byte, and it waits for the serial master to return a 12-bit result.

For each axis, the first result after the electrodes are switched is thrown away. The next `NAVG` results are summed in a narrow accumulator and divided by a shift. Once both axes are done, the block presents the X/Y pair and pulses `coord_valid` for one cycle. If the pen is lifted part way through, the capture is abandoned and nothing is reported. If the pen stays down, captures repeat one after another.

Top module: `touch_capture_seq`

## Requirements
- R1: After reset, `req_valid` and `coord_valid` are 0 and `coord_x` and `coord_y` are 0.
- R2: While `pen_irq_n` stays high, no request is issued.
- R3: The first request appears DEBOUNCE_CYC+3 rising edges after `pen_irq_n` is first driven low: two synchronizer stages, DEBOUNCE_CYC count steps and the state register. A low pulse shorter than DEBOUNCE_CYC cycles starts nothing.
- R4: A capture issues NAVG+1 requests with `req_cmd` = 0x90 (X, differential, power-down between conversions), then NAVG+1 requests with `req_cmd` = 0xD0 (Y).
- R5: The first result returned for each axis has no effect on the reported coordinate.
- R6: Each reported coordinate equals the sum of the NAVG retained 12-bit results shifted right by log2(NAVG), truncated. It does not overflow when every result is 0xFFF.
- R7: `coord_valid` is a one-cycle pulse in the cycle after the last Y result is accepted. `coord_x` and `coord_y` change only together with it and otherwise hold.
- R8: If the pen is released before the last Y result, no `coord_valid` is produced, no further requests are issued, and the outputs keep their previous values. The next capture starts from an empty accumulator.
- R9: A `rsp_valid` pulse that arrives while no request is outstanding is ignored.
- R10: While the pen stays low after a capture, the next capture starts without a new settle window.
- R11: `req_valid` is a one-cycle pulse. No further request is issued until a result for the current one has been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pen_irq_n | input | 1 | Pen interrupt from the touch controller, low while touched, asynchronous |
| req_valid | output | 1 | One-cycle conversion request to the serial master |
| req_cmd | output | 8 | Control byte for the requested conversion |
| rsp_valid | input | 1 | One-cycle strobe: conversion result available |
| rsp_data | input | 12 | Conversion result |
| coord_valid | output | 1 | One-cycle strobe: new coordinate pair |
| coord_x | output | 12 | Averaged X coordinate |
| coord_y | output | 12 | Averaged Y coordinate |

## Verification
The bench builds the block with DEBOUNCE_CYC = 8, NAVG = 4 and SYNC_STAGES = 2. The short settle window makes the exact edge count from pen-down to the first request practical to measure. It also lets a three-cycle glitch sit clearly inside the window. With four samples per axis, a batch of 0xFFF results fills the 14-bit accumulator to its top. A sum that is not a multiple of four exposes the truncating shift. Long pen-down phases give room for back-to-back captures and for a release in the middle of the Y batch.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int unsigned SAMPLE_W = 12;
  // start=1, channel 001 / 101, differential, power-down between conversions
  localparam logic [7:0] CMD_X = 8'h90;
  localparam logic [7:0] CMD_Y = 8'hD0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/tcs_sync.sv
module tcs_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/tcs_debounce.sv
module tcs_debounce #(
  parameter int unsigned DEB_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pen_down,
  output logic settled
);
  localparam int unsigned CW = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(DEB_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (!pen_down)             cnt_d = '0;
    else if (cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
    else                       cnt_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign settled = pen_down && (cnt_q == CNT_TOP);

  // R3: settling always comes after the pen was already seen down
  p_settle_after_pen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled) |-> $past(pen_down));
endmodule

// File: rtl/tcs_accum.sv
module tcs_accum #(
  parameter int unsigned IN_W = 12,
  parameter int unsigned NAVG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            add,
  input  logic [IN_W-1:0] din,
  output logic [IN_W-1:0] mean
);
  localparam int unsigned LOG2  = $clog2(NAVG);
  localparam int unsigned ACC_W = IN_W + LOG2;
  localparam int unsigned CW    = $clog2(NAVG + 1);

  logic [ACC_W-1:0] acc_q, acc_d, sum_w;
  logic             acc_en;

  assign sum_w = acc_q + ACC_W'(din);
  assign mean  = sum_w[ACC_W-1:LOG2];

  always_comb begin
    acc_en = clr || add;
    acc_d  = clr ? '0 : sum_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  // checker-side count of additions since the last clear
  logic [CW-1:0] adds_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   adds_q <= '0;
    else if (clr) adds_q <= '0;
    else if (add) adds_q <= adds_q + 1'b1;
  end

  // R6: the accumulator never holds more than NAVG-1 samples, so acc+din fits
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (add && !clr) |-> (adds_q < CW'(NAVG - 1)));
endmodule

// File: rtl/touch_capture_seq.sv
module touch_capture_seq
  import tcs_pkg::*;
#(
  parameter int unsigned DEBOUNCE_CYC = 50000,
  parameter int unsigned NAVG         = 4,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pen_irq_n,
  output logic                req_valid,
  output logic [7:0]          req_cmd,
  input  logic                rsp_valid,
  input  logic [SAMPLE_W-1:0] rsp_data,
  output logic                coord_valid,
  output logic [SAMPLE_W-1:0] coord_x,
  output logic [SAMPLE_W-1:0] coord_y
);
  localparam int unsigned CW = $clog2(NAVG + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(NAVG);

  logic rst_s, pen_s, pen_down, settled;

  tcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .din(1'b1), .dout(rst_s));

  tcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pen_sync (
    .clk(clk), .rst_n(rst_s), .din(pen_irq_n), .dout(pen_s));

  assign pen_down = !pen_s;

  tcs_debounce #(.DEB_CYC(DEBOUNCE_CYC)) u_deb (
    .clk(clk), .rst_n(rst_s), .pen_down(pen_down), .settled(settled));

  logic                acc_clr, acc_add;
  logic [SAMPLE_W-1:0] mean;

  tcs_accum #(.IN_W(SAMPLE_W), .NAVG(NAVG)) u_acc (
    .clk(clk), .rst_n(rst_s), .clr(acc_clr), .add(acc_add),
    .din(rsp_data), .mean(mean));

  seq_state_e          st_q, st_d;
  logic                axis_q, axis_d;     // 0 = X, 1 = Y
  logic [CW-1:0]       cnt_q, cnt_d;       // 0 = discard slot
  logic [SAMPLE_W-1:0] xh_q, xh_d;
  logic [SAMPLE_W-1:0] cx_q, cy_q;
  logic                out_en, xh_en, val_q;

  always_comb begin
    st_d    = st_q;
    axis_d  = axis_q;
    cnt_d   = cnt_q;
    xh_d    = xh_q;
    xh_en   = 1'b0;
    out_en  = 1'b0;
    acc_clr = 1'b0;
    acc_add = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        acc_clr = 1'b1;
        if (settled) begin
          st_d   = ST_REQ;
          axis_d = 1'b0;
          cnt_d  = '0;
        end
      end
      ST_REQ: st_d = pen_down ? ST_WAIT : ST_IDLE;
      ST_WAIT: begin
        if (!pen_down) begin
          st_d = ST_IDLE;
        end else if (rsp_valid) begin
          st_d = ST_REQ;
          if (cnt_q == '0) begin
            cnt_d = 1'b1;
          end else if (cnt_q == LAST_IDX) begin
            acc_clr = 1'b1;
            cnt_d   = '0;
            if (!axis_q) begin
              xh_d   = mean;
              xh_en  = 1'b1;
              axis_d = 1'b1;
            end else begin
              out_en = 1'b1;
              st_d   = ST_IDLE;
            end
          end else begin
            acc_add = 1'b1;
            cnt_d   = cnt_q + 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q   <= ST_IDLE;
      axis_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      axis_q <= axis_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      xh_q  <= '0;
      cx_q  <= '0;
      cy_q  <= '0;
      val_q <= 1'b0;
    end else begin
      val_q <= out_en;
      if (xh_en)  xh_q <= xh_d;
      if (out_en) begin
        cx_q <= xh_q;
        cy_q <= mean;
      end
    end
  end

  assign req_valid   = (st_q == ST_REQ);
  assign req_cmd     = axis_q ? CMD_Y : CMD_X;
  assign coord_valid = val_q;
  assign coord_x     = cx_q;
  assign coord_y     = cy_q;

  // R2: a request is only raised when the pen was down the cycle before
  p_req_pen_r2: assert property (@(posedge clk) disable iff (!rst_s)
    req_valid |-> $past(pen_down));
  // R11: requests are single-cycle pulses
  p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rst_s)
    req_valid |=> !req_valid);
  // R4: only the two axis control bytes ever go out
  p_cmd_legal_r4: assert property (@(posedge clk) disable iff (!rst_s)
    req_valid |-> (req_cmd == CMD_X || req_cmd == CMD_Y));
  // R7: valid is a pulse and coordinates move only with it
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_s)
    coord_valid |=> !coord_valid);
  p_coord_hold_r7: assert property (@(posedge clk) disable iff (!rst_s)
    !($stable(coord_x) && $stable(coord_y)) |-> coord_valid);
  // R8: a released pen never leads to a reported coordinate
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_s)
    !pen_down |=> !coord_valid);
endmodule

// File: tb/touch_capture_seq_tb_top.sv
module touch_capture_seq_tb_top;
  localparam int DEB = 8;
  localparam int NAV = 4;

  logic        clk = 1'b0;
  logic        rst_n, pen_irq_n, rsp_valid;
  logic [11:0] rsp_data;
  logic        req_valid, coord_valid;
  logic [7:0]  req_cmd;
  logic [11:0] coord_x, coord_y;

  touch_capture_seq #(.DEBOUNCE_CYC(DEB), .NAVG(NAV), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .pen_irq_n(pen_irq_n),
    .req_valid(req_valid), .req_cmd(req_cmd),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .coord_valid(coord_valid), .coord_x(coord_x), .coord_y(coord_y));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int req_cnt = 0, val_cnt = 0;
  bit done = 0;
  logic [11:0] samp [10];

  always @(negedge clk) begin
    if (req_valid)   req_cnt++;
    if (coord_valid) val_cnt++;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic wait_req(output bit ok);
    ok = 0;
    for (int k = 0; k < 300; k++) begin
      if (req_valid) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  // Serves a full capture from samp[], checks commands, timing and result
  task automatic serve_capture(string tag);
    bit ok;
    int sx, sy;
    sx = 0; sy = 0;
    for (int i = 1; i <= NAV; i++) begin
      sx += samp[i];
      sy += samp[NAV + 1 + i];
    end
    for (int i = 0; i < 2 * (NAV + 1); i++) begin
      wait_req(ok);
      check({tag, " R11 request arrives"}, ok, 1);
      check({tag, " R4 command order"}, req_cmd, (i <= NAV) ? 8'h90 : 8'hD0);
      repeat (3) begin
        @(negedge clk);
        check({tag, " R11 no request while outstanding"}, req_valid, 0);
      end
      rsp_valid = 1'b1; rsp_data = samp[i];
      @(negedge clk);
      rsp_valid = 1'b0;
    end
    check({tag, " R7 valid pulse"}, coord_valid, 1);
    check({tag, " R6 R5 x average"}, coord_x, sx >> 2);
    check({tag, " R6 R5 y average"}, coord_y, sy >> 2);
    @(negedge clk);
    check({tag, " R7 valid drops"}, coord_valid, 0);
    check({tag, " R7 x holds"}, coord_x, sx >> 2);
  endtask

  task automatic t_reset();
    check("R1 req after reset", req_valid, 0);
    check("R1 valid after reset", coord_valid, 0);
    check("R1 x after reset", coord_x, 0);
    check("R1 y after reset", coord_y, 0);
  endtask

  task automatic t_pen_high();
    int r0 = req_cnt;
    repeat (40) @(negedge clk);
    check("R2 no request while pen high", req_cnt, r0);
  endtask

  task automatic t_stray();
    int r0 = req_cnt, v0 = val_cnt;
    for (int k = 0; k < 3; k++) begin
      rsp_valid = 1'b1; rsp_data = 12'h5A5 + 12'(k);
      @(negedge clk);
      rsp_valid = 1'b0;
      @(negedge clk);
    end
    repeat (5) @(negedge clk);
    check("R9 stray response no valid", val_cnt, v0);
    check("R9 stray response no request", req_cnt, r0);
    check("R9 stray response x unchanged", coord_x, 0);
  endtask

  task automatic t_glitch();
    int r0 = req_cnt;
    pen_irq_n = 1'b0;
    repeat (3) @(negedge clk);
    pen_irq_n = 1'b1;
    repeat (30) @(negedge clk);
    check("R3 short glitch starts nothing", req_cnt, r0);
  endtask

  task automatic t_first_capture();
    int n = 0;
    pen_irq_n = 1'b0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      n++;
      if (req_valid) break;
    end
    check("R3 debounce latency", n, DEB + 3);
    samp[0] = 12'hFFF; samp[1] = 12'h100; samp[2] = 12'h101;
    samp[3] = 12'h102; samp[4] = 12'h104;
    samp[5] = 12'hABC; samp[6] = 12'h800; samp[7] = 12'h7FF;
    samp[8] = 12'h003; samp[9] = 12'h001;
    serve_capture("capA");
  endtask

  task automatic t_repeat();
    samp[0] = 12'h000;
    for (int i = 1; i <= 4; i++) samp[i] = 12'hFFF;
    samp[5] = 12'h123; samp[6] = 12'h000; samp[7] = 12'h000;
    samp[8] = 12'h000; samp[9] = 12'h003;
    serve_capture("capB R10");
  endtask

  task automatic t_abort();
    bit ok;
    int r0, v0;
    for (int i = 0; i < 7; i++) begin
      wait_req(ok);
      repeat (2) @(negedge clk);
      rsp_valid = 1'b1; rsp_data = 12'h777;
      @(negedge clk);
      rsp_valid = 1'b0;
    end
    wait_req(ok);
    check("R8 abort reached Y batch", req_cmd, 8'hD0);
    pen_irq_n = 1'b1;
    @(negedge clk);
    r0 = req_cnt; v0 = val_cnt;
    repeat (30) @(negedge clk);
    check("R8 abort no valid", val_cnt, v0);
    check("R8 abort no requests", req_cnt, r0);
    check("R8 abort x kept", coord_x, 12'hFFF);
    check("R8 abort y kept", coord_y, 12'h000);
  endtask

  task automatic t_after_abort();
    bit ok;
    pen_irq_n = 1'b0;
    wait_req(ok);
    samp[0] = 12'h010; samp[1] = 12'h004; samp[2] = 12'h004;
    samp[3] = 12'h004; samp[4] = 12'h008;
    samp[5] = 12'h020; samp[6] = 12'h00A; samp[7] = 12'h00A;
    samp[8] = 12'h00A; samp[9] = 12'h00A;
    serve_capture("capC R8 fresh accumulator");
    pen_irq_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; pen_irq_n = 1'b1; rsp_valid = 1'b0; rsp_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    t_reset();
    t_pen_high();
    t_stray();
    t_glitch();
    t_first_capture();
    t_repeat();
    t_abort();
    t_after_abort();
    repeat (5) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(100000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule